// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This controller turns two active-low sleep request lines, one for suspend-to-RAM and one for soft-off, into a power state: active, suspend-to-RAM or soft-off. From that state it drives the digital enables for a 3.3 V dual/standby rail, a 1.5 V standby rail and a 5 V dual rail. Both request lines pass through a two-flop synchronizer and then a deglitch filter. Entry into sleep waits for a programmable settling delay after the suspend line falls. The soft-off line is sampled only when that delay ends, and its level chooses which sleep state is entered.

Only moves between active and a sleep state are allowed. The reserved input pattern, with soft-off requested while the suspend line is high, freezes the controller. A standby power-on-reset input keeps every enable off and the state at active until it is released. A main-supply-good input qualifies the 5 V dual rail while the system is active. A build parameter chooses whether the 5 V dual rail stays on in soft-off.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: Each request line (`s3_ni`, `s5_ni`) is synchronized by two flops and then accepted only after its new level has held for FILT_CYCLES consecutive clocks. A shorter pulse changes nothing at the outputs.
- R2: While active, a filtered low on `s3_ni` starts a delay of SLEEP_DLY_CYCLES clocks. No sleep state is entered before the delay expires. If the filtered `s3_ni` returns high first, the delay is cancelled and the state stays active.
- R3: If filtered `s5_ni` is high when the delay expires, the state becomes suspend-to-RAM (`state_o` = 2'b01). In that state `en_3v3_dual_o`, `en_1v5_sb_o` and `en_5v_dual_o` are all 1.
- R4: If filtered `s5_ni` is low when the delay expires, the state becomes soft-off (`state_o` = 2'b10). In that state `en_3v3_dual_o` and `en_1v5_sb_o` are 1, and `en_5v_dual_o` equals the KEEP_5V_SOFTOFF parameter.
- R5: The state never moves directly between suspend-to-RAM and soft-off. While asleep, a filtered input pattern that requests the other sleep state leaves the state and the enables unchanged.
- R6: The reserved pattern (filtered `s5_ni` low with filtered `s3_ni` high) holds the present state and the enables, whether the controller is active or asleep.
- R7: While `por_ok_i` is 0, all three enables are 0, `state_o` is 2'b00 and any running delay is cleared. The standby enables rise only after `por_ok_i` becomes 1.
- R8: From either sleep state, the state returns to active (2'b00) on the clock after both filtered inputs are high, with no settling delay.
- R9: In the active state, `en_3v3_dual_o` and `en_1v5_sb_o` are 1 and `en_5v_dual_o` follows `main_pgood_i`.
- R10: `state_o` only takes the encodings 2'b00 (active), 2'b01 (suspend-to-RAM) and 2'b10 (soft-off). It never reads 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_ok_i | input | 1 | Standby supply above its power-on threshold |
| main_pgood_i | input | 1 | Main supply good |
| s3_ni | input | 1 | Suspend-to-RAM request, active low, asynchronous |
| s5_ni | input | 1 | Soft-off request, active low, asynchronous |
| en_3v3_dual_o | output | 1 | 3.3 V dual/standby rail enable |
| en_1v5_sb_o | output | 1 | 1.5 V standby rail enable |
| en_5v_dual_o | output | 1 | 5 V dual rail enable |
| state_o | output | 2 | Power state: 00 active, 01 suspend-to-RAM, 10 soft-off |

## Verification
The bench builds two instances with FILT_CYCLES = 4 and SLEEP_DLY_CYCLES = 40, both driven by the same inputs. One instance has KEEP_5V_SOFTOFF = 0 and the other has KEEP_5V_SOFTOFF = 1. The short filter lets the bench check a glitch exactly one cycle shorter than the acceptance length. The short delay lets it observe the state just before and well after the delay expires, and cancel the delay partway through. Together the two instances show both soft-off variants of the 5 V dual enable on every sleep path.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [1:0] {
    PST_ACTIVE = 2'b00,
    PST_STR    = 2'b01,
    PST_OFF    = 2'b10
  } pwr_state_e;
endpackage

// File: rtl/sleep_seq_sync.sv
module sleep_seq_sync #(
  parameter int unsigned WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sleep_seq_filter.sv
module sleep_seq_filter #(
  parameter int unsigned WIDTH       = 2,
  parameter int unsigned FILT_CYCLES = 100,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        lvl_q <= RST_VAL[b];
      end else if (d_i[b] == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        // level has held for the full window
        cnt_q <= '0;
        lvl_q <= d_i[b];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign q_o[b] = lvl_q;
  end
endmodule

// File: rtl/sleep_seq_timer.sv
module sleep_seq_timer #(
  parameter int unsigned DLY_CYCLES = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = (DLY_CYCLES > 1) ? $clog2(DLY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import sleep_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       s3_i,
  input  logic       s5_i,
  input  logic       expire_i,
  output logic       run_o,
  output pwr_state_e state_o
);
  pwr_state_e state_q, state_d;

  assign run_o = !clr_i && (state_q == PST_ACTIVE) && !s3_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PST_ACTIVE: if (expire_i) state_d = s5_i ? PST_STR : PST_OFF;
      PST_STR,
      PST_OFF:    if (s3_i && s5_i) state_d = PST_ACTIVE;
      default:    state_d = PST_ACTIVE;
    endcase
    if (clr_i) state_d = PST_ACTIVE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PST_ACTIVE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
#(
  parameter int unsigned FILT_CYCLES      = 100,
  parameter int unsigned SLEEP_DLY_CYCLES = 10000,
  parameter bit          KEEP_5V_SOFTOFF  = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_ok_i,
  input  logic       main_pgood_i,
  input  logic       s3_ni,
  input  logic       s5_ni,
  output logic       en_3v3_dual_o,
  output logic       en_1v5_sb_o,
  output logic       en_5v_dual_o,
  output logic [1:0] state_o
);
  localparam int unsigned NREQ = 2;  // bit 0: suspend line, bit 1: soft-off line

  logic [NREQ-1:0] req_sync, req_filt;
  logic            expire, run;
  pwr_state_e      state;

  sleep_seq_sync #(.WIDTH(NREQ), .RST_VAL('1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({s5_ni, s3_ni}),
    .q_o    (req_sync)
  );

  sleep_seq_filter #(.WIDTH(NREQ), .FILT_CYCLES(FILT_CYCLES), .RST_VAL('1)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_sync),
    .q_o    (req_filt)
  );

  sleep_seq_timer #(.DLY_CYCLES(SLEEP_DLY_CYCLES)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .expire_o (expire)
  );

  sleep_seq_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!por_ok_i),
    .s3_i     (req_filt[0]),
    .s5_i     (req_filt[1]),
    .expire_i (expire),
    .run_o    (run),
    .state_o  (state)
  );

  always_comb begin
    en_3v3_dual_o = por_ok_i;
    en_1v5_sb_o   = por_ok_i;
    unique case (state)
      PST_ACTIVE: en_5v_dual_o = por_ok_i && main_pgood_i;
      PST_STR:    en_5v_dual_o = por_ok_i;
      PST_OFF:    en_5v_dual_o = por_ok_i && KEEP_5V_SOFTOFF;
      default:    en_5v_dual_o = 1'b0;
    endcase
  end

  assign state_o = state;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
  parameter bit KEEP_5V = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_ok_i,
  input logic       main_pgood_i,
  input logic       en_3v3_dual_o,
  input logic       en_1v5_sb_o,
  input logic       en_5v_dual_o,
  input logic [1:0] state_o
);
  p_no_str_to_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01) |=> (state_o != 2'b10));

  p_no_off_to_str_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10) |=> (state_o != 2'b01));

  p_state_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11);

  p_por_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> (state_o == 2'b00));

  p_por_rails_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |-> (!en_3v3_dual_o && !en_1v5_sb_o && !en_5v_dual_o));

  p_str_rails_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_ok_i && state_o == 2'b01) |-> (en_3v3_dual_o && en_1v5_sb_o && en_5v_dual_o));

  p_off_rails_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_ok_i && state_o == 2'b10) |-> (en_3v3_dual_o && en_5v_dual_o == KEEP_5V));

  p_active_rails_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_ok_i && state_o == 2'b00) |-> (en_1v5_sb_o && en_5v_dual_o == main_pgood_i));
endmodule

bind sleep_seq_ctrl sleep_seq_chk #(.KEEP_5V(KEEP_5V_SOFTOFF)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .por_ok_i      (por_ok_i),
  .main_pgood_i  (main_pgood_i),
  .en_3v3_dual_o (en_3v3_dual_o),
  .en_1v5_sb_o   (en_1v5_sb_o),
  .en_5v_dual_o  (en_5v_dual_o),
  .state_o       (state_o)
);

// File: tb/sim_sleep_seq_ctrl.sv
module sim_sleep_seq_ctrl;
  localparam int unsigned FILT = 4;
  localparam int unsigned DLY  = 40;
  localparam int unsigned LAT  = 2 + FILT;  // sync + filter

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_ok = 1'b0, pgood = 1'b0, s3_n = 1'b1, s5_n = 1'b1;
  logic e33_a, e15_a, e5_a, e33_b, e15_b, e5_b;
  logic [1:0] st_a, st_b;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sleep_seq_ctrl #(.FILT_CYCLES(FILT), .SLEEP_DLY_CYCLES(DLY), .KEEP_5V_SOFTOFF(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_ok_i(por_ok), .main_pgood_i(pgood),
    .s3_ni(s3_n), .s5_ni(s5_n), .en_3v3_dual_o(e33_a), .en_1v5_sb_o(e15_a),
    .en_5v_dual_o(e5_a), .state_o(st_a));

  sleep_seq_ctrl #(.FILT_CYCLES(FILT), .SLEEP_DLY_CYCLES(DLY), .KEEP_5V_SOFTOFF(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .por_ok_i(por_ok), .main_pgood_i(pgood),
    .s3_ni(s3_n), .s5_ni(s5_n), .en_3v3_dual_o(e33_b), .en_1v5_sb_o(e15_b),
    .en_5v_dual_o(e5_b), .state_o(st_b));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // packs {st_b, e5_b, e5_a, e15_a, e33_a, st_a}
  function automatic logic [7:0] snap();
    return {st_b, e5_b, e5_a, e15_a, e33_a, st_a};
  endfunction

  function automatic logic [7:0] expv(input logic [1:0] st, input logic e5a, input logic e5b,
                                      input logic sb);
    return {st, e5b, e5a, sb, sb, st};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(3);
    check("R7 reset/por low", snap(), expv(2'b00, 0, 0, 0));
    pgood = 1'b1;
    cyc(2);
    check("R7 pgood without por", snap(), expv(2'b00, 0, 0, 0));
    por_ok = 1'b1;
    cyc(1);
    check("R9 active rails", snap(), expv(2'b00, 1, 1, 1));
    pgood = 1'b0;
    cyc(1);
    check("R9 5v follows pgood", snap(), expv(2'b00, 0, 0, 1));
    pgood = 1'b1;
    cyc(1);
  endtask

  task automatic t_glitch();
    s3_n = 1'b0; cyc(FILT - 1); s3_n = 1'b1;
    cyc(LAT + DLY + 10);
    check("R1 short glitch ignored", snap(), expv(2'b00, 1, 1, 1));
  endtask

  task automatic t_cancel();
    s3_n = 1'b0; cyc(LAT + DLY / 2); s3_n = 1'b1;
    cyc(DLY + LAT + 10);
    check("R2 cancelled delay stays active", snap(), expv(2'b00, 1, 1, 1));
  endtask

  task automatic t_enter_str();
    s3_n = 1'b0;
    cyc(LAT + DLY - 6);
    check("R2 no sleep before delay", snap(), expv(2'b00, 1, 1, 1));
    cyc(16);
    check("R3 suspend entered", snap(), expv(2'b01, 1, 1, 1));
  endtask

  task automatic t_str_ignore();
    s5_n = 1'b0;
    cyc(LAT + DLY + 10);
    check("R5 off request ignored in suspend", snap(), expv(2'b01, 1, 1, 1));
    s5_n = 1'b1;
    cyc(LAT + 4);
    check("R5 still suspend", snap(), expv(2'b01, 1, 1, 1));
    s3_n = 1'b1; s5_n = 1'b0;
    cyc(LAT + 10);
    check("R6 reserved holds suspend", snap(), expv(2'b01, 1, 1, 1));
  endtask

  task automatic t_wake();
    s5_n = 1'b1; s3_n = 1'b1;
    cyc(LAT + 3);
    check("R8 wake without delay", snap(), expv(2'b00, 1, 1, 1));
  endtask

  task automatic t_enter_off();
    s3_n = 1'b0; s5_n = 1'b0;
    cyc(LAT + DLY - 6);
    check("R2 no soft-off before delay", snap(), expv(2'b00, 1, 1, 1));
    cyc(16);
    check("R4 soft-off entered", snap(), expv(2'b10, 0, 1, 1));
  endtask

  task automatic t_off_ignore();
    s5_n = 1'b1;
    cyc(LAT + DLY + 10);
    check("R5 suspend request ignored in soft-off", snap(), expv(2'b10, 0, 1, 1));
    s5_n = 1'b0;
    cyc(LAT + 4);
    s3_n = 1'b1;
    cyc(LAT + DLY + 10);
    check("R6 reserved holds soft-off", snap(), expv(2'b10, 0, 1, 1));
    s5_n = 1'b1;
    cyc(LAT + 3);
    check("R8 wake from soft-off", snap(), expv(2'b00, 1, 1, 1));
  endtask

  task automatic t_reserved_active();
    s5_n = 1'b0;
    cyc(LAT + DLY + 10);
    check("R6 reserved holds active", snap(), expv(2'b00, 1, 1, 1));
    s5_n = 1'b1;
    cyc(LAT + 2);
  endtask

  task automatic t_por_drop();
    s3_n = 1'b0;
    cyc(LAT + DLY + 5);
    check("R3 suspend before por drop", st_a, 8'h01);
    por_ok = 1'b0;
    cyc(1);
    check("R7 por drop clears", snap(), expv(2'b00, 0, 0, 0));
    cyc(5);
    por_ok = 1'b1;
    cyc(LAT + DLY - 8);
    check("R7 delay restarted after por", snap(), expv(2'b00, 1, 1, 1));
    cyc(16);
    check("R10 re-entered suspend", snap(), expv(2'b01, 1, 1, 1));
    s3_n = 1'b1;
    cyc(LAT + 3);
  endtask

  initial begin : watchdog
    #(20 * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(2);
    rst_n = 1'b1;
    t_reset();
    t_glitch();
    t_cancel();
    t_enter_str();
    t_str_ignore();
    t_wake();
    t_enter_off();
    t_off_ignore();
    t_reserved_active();
    t_por_drop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule